// File: doc/BRIEF.md
# Synchronized Reciprocal-Counter Measurement Gate

This block decides when the two accumulators of a reciprocal frequency/period counter may count. One accumulator counts cycles of the measured input signal. The other counts cycles of a fast reference time base, nominally 320 MHz. The controller requests a measurement by pulling an active-low gate request low while an active-low arm input is also low. A master reset, applied before every measurement, forces both gates shut and clears both accumulators.

Two cascaded synchronizer state machines make sure each accumulator sees only whole pulses. The input stage runs on rising edges of the measured signal. The time-base stage runs on rising edges of the reference clock and follows the input stage. Both accumulators count on the opposite (falling) edge of their own clock, so a gate never opens or closes in the middle of a pulse. Once both gates have closed, an active-low end flag tells the controller that it can read the two counts. The counts stay on the output ports, unchanged, until the next master reset.

Input-stage states:
- `IN_IDLE`: the gate is closed and waits for a request.
- `IN_OPEN`: the event gate is open.
- `IN_CLOSED`: the gate is closed and cannot reopen.

Input-stage transitions:
- `IN_IDLE`→`IN_OPEN` when both the request and the arm input are low at an input rising edge.
- `IN_OPEN`→`IN_CLOSED` when either of those two inputs is high at an input rising edge.

Time-base-stage states:
- `TB_IDLE`: the gate is closed and the stage waits for the input stage.
- `TB_OPEN`: the time-base gate is open.
- `TB_DONE`: the gate is closed and the end flag is driven low.

Time-base-stage transitions, each taken at a time-base rising edge:
- `TB_IDLE`→`TB_OPEN` when the input stage is open.
- `TB_IDLE`→`TB_DONE` when the input stage has already opened and closed between two reference edges.
- `TB_OPEN`→`TB_DONE` when the input stage is no longer open.

A mode input selects between two kinds of operation:
- Frequency/period mode (`total_mode` = 0): the time-base accumulator counts.
- Totalize mode (`total_mode` = 1): the time-base accumulator is held disabled, and the gates and the end flag behave exactly as in frequency/period mode.

Top module: `rcg_meas_gate`

## Requirements
- R1: While `mr` is high, both gate outputs are 0, both counts are 0 and `end_n` is 1.
- R2: The event gate stays closed, and the event count stays 0, for as long as `gate_n` or `arm_n` is high at every rising edge of `inp_sig`.
- R3: `ev_gate` goes to 1 at the first rising edge of `inp_sig` at which `gate_n` and `arm_n` are both low. The first event counted is the next falling edge of `inp_sig`, and every later falling edge adds one while the gate is open.
- R4: In frequency/period mode, `tb_gate` goes to 1 at the first rising edge of `tb_clk` at which the event gate is open. The first time-base cycle counted is the next falling edge of `tb_clk`.
- R5: `ev_gate` returns to 0 at the first rising edge of `inp_sig` at which `gate_n` (or `arm_n`) is high. It does not reopen until the next master reset, even if the request goes low again.
- R6: After the event gate has closed, the next rising edge of `tb_clk` closes `tb_gate` and drives `end_n` to 0. `end_n` stays 0 until master reset.
- R7: While `end_n` is 0, both counts hold their final values.
- R8: In totalize mode (`total_mode` = 1), `tb_count` stays 0, while the event gate and `end_n` still behave as in R3, R5 and R6.
- R9: After a frequency/period measurement, `tb_count`·T_tb and `ev_count`·T_in differ by less than one time-base period T_tb. In other words, the ratio of the counts matches the ratio of the clock periods to within one count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mr | input | 1 | Master reset, active high, asynchronous |
| inp_sig | input | 1 | Measured input signal; it clocks the input stage and the event accumulator |
| tb_clk | input | 1 | Reference time-base clock |
| gate_n | input | 1 | Measurement gate request from the controller, active low |
| arm_n | input | 1 | Arming input, active low |
| total_mode | input | 1 | 0 = frequency/period, 1 = totalize (time-base accumulator disabled) |
| ev_gate | output | 1 | Event accumulator gate is open |
| tb_gate | output | 1 | Time-base accumulator gate is open |
| end_n | output | 1 | End of measurement, active low |
| ev_count | output | CNT_W | Event accumulator value |
| tb_count | output | CNT_W | Time-base accumulator value |

## Verification
The results fall due on edges of three different clocks:
- `ev_gate` changes on the same rising edge of `inp_sig` that samples the request.
- `tb_gate` and `end_n` change one `tb_clk` rising edge after the event gate changes.
- Each count moves on the falling edge that follows the matching gate change.

The bench's behavioural model updates on those same edges. The bench then compares every output against the model at each falling edge of its 100 MHz bench clock. The edge timings are chosen with odd picosecond offsets, and every sampling instant and input change falls on an even picosecond, so no comparison ever coincides with a design edge. After each measurement, further directed checks cover the hold of the counts, the ban on reopening, and the count ratio.

// File: rtl/rcg_pkg.sv
`timescale 1ps/1ps
package rcg_pkg;
    typedef enum logic [1:0] {
        IN_IDLE   = 2'd0,
        IN_OPEN   = 2'd1,
        IN_CLOSED = 2'd2
    } in_state_t;

    typedef enum logic [1:0] {
        TB_IDLE = 2'd0,
        TB_OPEN = 2'd1,
        TB_DONE = 2'd2
    } tb_state_t;
endpackage

// File: rtl/rcg_input_stage.sv
`timescale 1ps/1ps
module rcg_input_stage
    import rcg_pkg::*;
(
    input  logic inp_sig,
    input  logic mr,
    input  logic gate_n,
    input  logic arm_n,
    output logic ev_open,
    output logic ev_done
);
    in_state_t state_q;
    in_state_t state_d;
    logic      hold_req;

    // synchronizer D input: low only when request and arm are both low
    assign hold_req = gate_n | arm_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IN_IDLE:   if (!hold_req) state_d = IN_OPEN;
            IN_OPEN:   if (hold_req)  state_d = IN_CLOSED;
            IN_CLOSED: state_d = IN_CLOSED;
            default:   state_d = IN_IDLE;
        endcase
    end

    always_ff @(posedge inp_sig or posedge mr) begin
        if (mr) state_q <= IN_IDLE;
        else    state_q <= state_d;
    end

    always_comb begin
        ev_open = 1'b0;
        ev_done = 1'b0;
        unique case (state_q)
            IN_IDLE:   ;
            IN_OPEN:   ev_open = 1'b1;
            IN_CLOSED: ev_done = 1'b1;
            default:   ;
        endcase
    end

    AST_NO_OPEN_WITHOUT_REQ: assert property (@(posedge inp_sig) disable iff (mr)
        (!ev_open && !ev_done && hold_req) |=> !ev_open); // R2

    AST_NO_REOPEN: assert property (@(posedge inp_sig) disable iff (mr)
        ev_done |=> (ev_done && !ev_open)); // R5
endmodule

// File: rtl/rcg_tb_stage.sv
`timescale 1ps/1ps
module rcg_tb_stage
    import rcg_pkg::*;
(
    input  logic tb_clk,
    input  logic mr,
    input  logic ev_open,
    input  logic ev_done,
    output logic tb_open,
    output logic end_n
);
    tb_state_t state_q;
    tb_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TB_IDLE: begin
                if (ev_open)      state_d = TB_OPEN;
                else if (ev_done) state_d = TB_DONE;
            end
            TB_OPEN: if (!ev_open) state_d = TB_DONE;
            TB_DONE: state_d = TB_DONE;
            default: state_d = TB_IDLE;
        endcase
    end

    always_ff @(posedge tb_clk or posedge mr) begin
        if (mr) state_q <= TB_IDLE;
        else    state_q <= state_d;
    end

    always_comb begin
        tb_open = 1'b0;
        end_n   = 1'b1;
        unique case (state_q)
            TB_IDLE: ;
            TB_OPEN: tb_open = 1'b1;
            TB_DONE: end_n   = 1'b0;
            default: ;
        endcase
    end

    AST_TB_OPENS_AFTER_EV: assert property (@(posedge tb_clk) disable iff (mr)
        $rose(tb_open) |-> ev_open); // R4

    AST_END_AFTER_EV_CLOSE: assert property (@(posedge tb_clk) disable iff (mr)
        $fell(end_n) |-> (ev_done && !ev_open)); // R6

    AST_END_HELD: assert property (@(posedge tb_clk) disable iff (mr)
        !end_n |=> !end_n); // R6
endmodule

// File: rtl/rcg_accum.sv
`timescale 1ps/1ps
module rcg_accum #(
    parameter int CNT_W = 32
) (
    input  logic             cnt_clk,
    input  logic             mr,
    input  logic             cnt_en,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

    // counts on the falling edge so that a gate opened on a rising edge
    // only ever admits whole pulses
    always_ff @(negedge cnt_clk or posedge mr) begin
        if (mr)          count <= '0;
        else if (cnt_en) count <= count + STEP;
    end

    AST_CLEAR_IN_RESET: assert property (@(negedge cnt_clk)
        mr |-> (count == '0)); // R1
endmodule

// File: rtl/rcg_meas_gate.sv
`timescale 1ps/1ps
module rcg_meas_gate #(
    parameter int CNT_W = 32
) (
    input  logic             mr,
    input  logic             inp_sig,
    input  logic             tb_clk,
    input  logic             gate_n,
    input  logic             arm_n,
    input  logic             total_mode,
    output logic             ev_gate,
    output logic             tb_gate,
    output logic             end_n,
    output logic [CNT_W-1:0] ev_count,
    output logic [CNT_W-1:0] tb_count
);
    logic ev_open;
    logic ev_done;
    logic tb_open;
    logic tb_cnt_en;

    rcg_input_stage u_in_stage (
        .inp_sig (inp_sig),
        .mr      (mr),
        .gate_n  (gate_n),
        .arm_n   (arm_n),
        .ev_open (ev_open),
        .ev_done (ev_done)
    );

    rcg_tb_stage u_tb_stage (
        .tb_clk  (tb_clk),
        .mr      (mr),
        .ev_open (ev_open),
        .ev_done (ev_done),
        .tb_open (tb_open),
        .end_n   (end_n)
    );

    assign tb_cnt_en = tb_open & ~total_mode;

    rcg_accum #(.CNT_W(CNT_W)) u_ev_acc (
        .cnt_clk (inp_sig),
        .mr      (mr),
        .cnt_en  (ev_open),
        .count   (ev_count)
    );

    rcg_accum #(.CNT_W(CNT_W)) u_tb_acc (
        .cnt_clk (tb_clk),
        .mr      (mr),
        .cnt_en  (tb_cnt_en),
        .count   (tb_count)
    );

    assign ev_gate = ev_open;
    assign tb_gate = tb_open;

    AST_COUNTS_FROZEN_AT_END: assert property (@(posedge tb_clk) disable iff (mr)
        !end_n |=> ($stable(tb_count) && $stable(ev_count))); // R7

    AST_TOTALIZE_NO_TB: assert property (@(posedge tb_clk) disable iff (mr)
        total_mode |-> (tb_count == '0)); // R8
endmodule

// File: tb/test_rcg_meas_gate.sv
`timescale 1ps/1ps
module test_rcg_meas_gate;
    localparam int  CNT_W   = 32;
    localparam int  IN_HALF = 18502;
    localparam int  TB_HALF = 1562;
    localparam longint T_IN = 2 * IN_HALF;
    localparam longint T_TB = 2 * TB_HALF;

    logic clk = 1'b0;
    logic inp_sig = 1'b0;
    logic tb_clk = 1'b0;
    logic mr = 1'b1;
    logic gate_n = 1'b1;
    logic arm_n = 1'b1;
    logic total_mode = 1'b0;
    logic ev_gate, tb_gate, end_n;
    logic [CNT_W-1:0] ev_count, tb_count;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    // reference model state
    int     m_in = 0;   // 0 idle, 1 open, 2 closed
    int     m_tb = 0;   // 0 idle, 1 open, 2 done
    longint m_evc = 0;
    longint m_tbc = 0;

    rcg_meas_gate #(.CNT_W(CNT_W)) i_rcg_meas_gate (
        .mr(mr), .inp_sig(inp_sig), .tb_clk(tb_clk), .gate_n(gate_n),
        .arm_n(arm_n), .total_mode(total_mode), .ev_gate(ev_gate),
        .tb_gate(tb_gate), .end_n(end_n), .ev_count(ev_count), .tb_count(tb_count)
    );

    // 100 MHz bench clock; design clocks switch on odd picoseconds only
    initial forever #5000 clk = ~clk;
    initial begin #3; forever #IN_HALF inp_sig = ~inp_sig; end
    initial begin #7; forever #TB_HALF tb_clk = ~tb_clk; end

    always @(posedge inp_sig or posedge mr) begin
        if (mr) m_in <= 0;
        else if (m_in == 0 && !gate_n && !arm_n) m_in <= 1;
        else if (m_in == 1 && (gate_n || arm_n)) m_in <= 2;
    end
    always @(negedge inp_sig or posedge mr) begin
        if (mr) m_evc <= 0;
        else if (m_in == 1) m_evc <= m_evc + 1;
    end
    always @(posedge tb_clk or posedge mr) begin
        if (mr) m_tb <= 0;
        else if (m_tb == 0 && m_in == 1) m_tb <= 1;
        else if (m_tb == 0 && m_in == 2) m_tb <= 2;
        else if (m_tb == 1 && m_in != 1) m_tb <= 2;
    end
    always @(negedge tb_clk or posedge mr) begin
        if (mr) m_tbc <= 0;
        else if (m_tb == 1 && !total_mode) m_tbc <= m_tbc + 1;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R3/R5 ev_gate", longint'(ev_gate), longint'(m_in == 1));
            chk("R4 tb_gate", longint'(tb_gate), longint'(m_tb == 1));
            chk("R6 end_n", longint'(end_n), longint'(m_tb != 2));
            chk("R3 ev_count", longint'(ev_count), m_evc);
            chk("R4 tb_count", longint'(tb_count), m_tbc);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !finished) begin
            errors++;
            $display("FAIL R6 watchdog actual=%0d expected<=%0d", cyc, 200000);
            finish_run();
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic pulse_reset(input logic tot);
        @(posedge clk);
        mr = 1'b1;
        gate_n = 1'b1;
        arm_n = 1'b1;
        total_mode = tot;
        wait_clks(3);
        @(negedge clk);
        chk("R1 ev_gate", longint'(ev_gate), 0);
        chk("R1 tb_gate", longint'(tb_gate), 0);
        chk("R1 end_n", longint'(end_n), 1);
        chk("R1 ev_count", longint'(ev_count), 0);
        chk("R1 tb_count", longint'(tb_count), 0);
        @(posedge clk);
        mr = 1'b0;
        wait_clks(2);
    endtask

    // runs one measurement of 'len' bench cycles, then checks hold and no reopen
    task automatic measure(input int len, input bit ratio_chk);
        longint ev_f, tb_f, diff;
        @(posedge clk);
        gate_n = 1'b0;
        arm_n = 1'b0;
        wait_clks(len);
        gate_n = 1'b1;
        wait_clks(20);
        @(negedge clk);
        chk("R6 end_n low after close", longint'(end_n), 0);
        ev_f = longint'(ev_count);
        tb_f = longint'(tb_count);
        @(posedge clk);
        gate_n = 1'b0;               // a fresh request must not reopen
        wait_clks(40);
        @(negedge clk);
        chk("R5 no reopen", longint'(ev_gate), 0);
        chk("R7 ev_count held", longint'(ev_count), ev_f);
        chk("R7 tb_count held", longint'(tb_count), tb_f);
        if (ratio_chk) begin
            diff = tb_f * T_TB - ev_f * T_IN;
            if (diff < 0) diff = -diff;
            chk("R9 ratio within one count", longint'(diff < T_TB), 1);
            chk("R9 events nonzero", longint'(ev_f > 0), 1);
        end
        @(posedge clk);
        gate_n = 1'b1;
    endtask

    initial begin
        cmp_on = 1'b1;
        // frequency/period mode, first hold off with arm high
        pulse_reset(1'b0);
        @(posedge clk);
        gate_n = 1'b0;
        wait_clks(30);
        @(negedge clk);
        chk("R2 gate closed with arm high", longint'(ev_gate), 0);
        chk("R2 no events with arm high", longint'(ev_count), 0);
        @(posedge clk);
        gate_n = 1'b1;
        arm_n = 1'b0;
        wait_clks(30);
        @(negedge clk);
        chk("R2 gate closed with request high", longint'(ev_gate), 0);
        arm_n = 1'b1;
        measure(3000, 1'b1);

        // totalize mode
        pulse_reset(1'b1);
        measure(1500, 1'b0);
        @(negedge clk);
        chk("R8 tb_count stays zero", longint'(tb_count), 0);
        chk("R8 events counted", longint'(ev_count > 0), 1);

        // short and a longer frequency measurement
        pulse_reset(1'b0);
        measure(37, 1'b1);
        pulse_reset(1'b0);
        measure(5000, 1'b1);

        finish_run();
    end
endmodule